// File: doc/BRIEF.md
# Two-Stage Serial Bit Clock Divider

This block derives the bit clock of a synchronous serial port from the system clock. It uses two divide stages in cascade. The first stage takes an even prescale value P. The second stage divides that result by (1 + S), where S is an 8-bit rate value. One full serial clock period is therefore P × (1 + S) system cycles. The settings run from divide-by-2 (P = 2, S = 0) down to divide-by-65024 (P = 254, S = 255).

The serial clock is produced as a registered level. Two one-cycle strobes come with it and mark each rising and each falling transition, so a shifter running on the system clock can launch and capture data without a second clock domain. The clock runs only while the port is enabled and a frame is in progress. Otherwise it rests at the programmed polarity level. Divisor settings are captured only between frames, which keeps every bit of a frame the same length.

Top module: `sclk_divider`

## Requirements
- R1: Take P as the prescale input with bit 0 forced to 0, and raise it to 2 if it is below 2. While running, the clock changes level every (P/2) × (1 + S) system cycles, so the spacing from one rising strobe to the next is P × (1 + S) cycles.
- R2: With prescale 2 and rate 0, the serial clock changes level on every system clock edge while running. Its period is then 2 cycles.
- R3: The block is running when enable and frameActive are both 1. On any clock edge where it is not running, `sclk` is loaded with `cpol`, no strobe is produced and the divide counters return to zero. After the next frame starts, the first transition again comes one full half-period after the start.
- R4: When running begins, the first transition appears on the outputs just after the H-th rising clock edge at which running was sampled, where H = (P/2) × (1 + S). This first transition is a rise when `cpol` is 0 and a fall when `cpol` is 1.
- R5: `riseStb` is 1 for exactly the one cycle in which `sclk` has just gone from 0 to 1. `fallStb` is 1 for exactly the one cycle in which `sclk` has just gone from 1 to 0. The two strobes are never 1 together, and neither repeats on consecutive cycles.
- R6: The prescale and rate inputs are sampled only on clock edges where the block is not running. Changes made during a frame do not alter that frame's bit length; they take effect from the next frame.
- R7: Bit 0 of the prescale input has no effect: 5 divides like 4, and 255 divides like 254. Prescale inputs 0 and 1 divide like 2.
- R8: The slowest setting, prescale 254 (or 255) with rate 255, gives a half-period of 32512 cycles and a period of 65024 cycles.
- R9: During synchronous reset (`rstN` = 0), `sclk`, `riseStb` and `fallStb` are 0. The captured divisors return to prescale 2 and rate 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Port enable |
| frameActive | input | 1 | A frame is in progress |
| cpol | input | 1 | Idle level of the serial clock |
| prescaleIn | input | 8 | First-stage divisor (even, 2 to 254) |
| rateIn | input | 8 | Second-stage value S, divides by 1 + S |
| sclk | output | 1 | Serial clock level |
| riseStb | output | 1 | One-cycle strobe after a rising transition |
| fallStb | output | 1 | One-cycle strobe after a falling transition |

## Verification
The assertions assume the reset is synchronous. They also assume the divisor inputs are single-clock-domain values that settle before the edge on which they are captured. The idle-level check further relies on `cpol` being read at the same edge that loads `sclk`. The bench drives every input on the falling clock edge, so each rising edge sees stable values. It changes the divisors mid-frame only to show that they are ignored until the next idle edge. It holds each frame open until the strobes it measures have appeared.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

  // Strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic run;      // enable and frame both present
    logic loadDiv;  // frame boundary: capture divisor inputs
    logic preWrap;  // first stage completes one count this cycle
    logic edgeNow;  // both stages complete: serial clock changes level
  } divCtl_t;

endpackage

// File: rtl/sclkdiv_wrapcnt.sv
module sclkdiv_wrapcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         advance,
  input  logic [W-1:0] limit,
  output logic         atEnd,
  output logic [W-1:0] count
);

  assign atEnd = (count == limit);

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      count <= '0;
    end else if (advance) begin
      count <= atEnd ? '0 : count + W'(1);
    end
  end

  // The limit is changed only while the counter is held at zero
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= limit); // R1

endmodule

// File: rtl/sclkdiv_ctrl.sv
module sclkdiv_ctrl
  import sclkdiv_pkg::*;
(
  input  logic    enable,
  input  logic    frameActive,
  input  logic    preAtEnd,
  input  logic    rateAtEnd,
  output divCtl_t ctl
);

  typedef enum logic { PH_IDLE = 1'b0, PH_RUN = 1'b1 } phase_t;

  phase_t phase;

  always_comb begin
    phase = (enable && frameActive) ? PH_RUN : PH_IDLE;
    ctl   = '0;
    unique case (phase)
      PH_IDLE: begin
        ctl.loadDiv = 1'b1;
      end
      PH_RUN: begin
        ctl.run     = 1'b1;
        ctl.preWrap = preAtEnd;
        ctl.edgeNow = preAtEnd && rateAtEnd;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/sclkdiv_datapath.sv
module sclkdiv_datapath
  import sclkdiv_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtl_t          ctl,
  input  logic [DIV_W-1:0] prescaleIn,
  input  logic [DIV_W-1:0] rateIn,
  input  logic             cpol,
  output logic             preAtEnd,
  output logic             rateAtEnd,
  output logic             sclk,
  output logic             riseStb,
  output logic             fallStb
);

  localparam int HALF_W = DIV_W - 1;

  logic [HALF_W-1:0] halfPreIn;
  logic [HALF_W-1:0] halfPreLat;
  logic [DIV_W-1:0]  rateLat;
  logic [HALF_W-1:0] preCount;
  logic [DIV_W-1:0]  rateCount;
  logic              pastValid;

  // An even prescale P gives half-period steps of P/2; bit 0 is dropped and
  // values below 2 act as 2
  assign halfPreIn = (prescaleIn < DIV_W'(2)) ? HALF_W'(1) : prescaleIn[DIV_W-1:1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfPreLat <= HALF_W'(1);
      rateLat    <= '0;
    end else if (ctl.loadDiv) begin
      halfPreLat <= halfPreIn;
      rateLat    <= rateIn;
    end
  end

  sclkdiv_wrapcnt #(.W(HALF_W)) u_preStage (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (!ctl.run),
    .advance (ctl.run),
    .limit   (halfPreLat - HALF_W'(1)),
    .atEnd   (preAtEnd),
    .count   (preCount)
  );

  sclkdiv_wrapcnt #(.W(DIV_W)) u_rateStage (
    .clk     (clk),
    .rstN    (rstN),
    .clear   (!ctl.run),
    .advance (ctl.preWrap),
    .limit   (rateLat),
    .atEnd   (rateAtEnd),
    .count   (rateCount)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclk    <= 1'b0;
      riseStb <= 1'b0;
      fallStb <= 1'b0;
    end else if (!ctl.run) begin
      sclk    <= cpol;
      riseStb <= 1'b0;
      fallStb <= 1'b0;
    end else begin
      riseStb <= ctl.edgeNow && !sclk;
      fallStb <= ctl.edgeNow && sclk;
      if (ctl.edgeNow) sclk <= !sclk;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(riseStb && fallStb)); // R5
  AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |-> sclk); // R5
  AST_FALL_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |-> !sclk); // R5
  AST_NO_DOUBLE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |=> !riseStb); // R5
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(!ctl.run)) |-> (sclk == $past(cpol) && !riseStb && !fallStb)); // R3
  AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && ctl.run && $past(ctl.run)) |-> ($stable(halfPreLat) && $stable(rateLat))); // R6
  AST_STAGE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(!ctl.run)) |-> (preCount == '0 && rateCount == '0)); // R3

endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclkdiv_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             frameActive,
  input  logic             cpol,
  input  logic [DIV_W-1:0] prescaleIn,
  input  logic [DIV_W-1:0] rateIn,
  output logic             sclk,
  output logic             riseStb,
  output logic             fallStb
);

  divCtl_t ctl;
  logic    preAtEnd;
  logic    rateAtEnd;

  sclkdiv_ctrl u_ctrl (
    .enable      (enable),
    .frameActive (frameActive),
    .preAtEnd    (preAtEnd),
    .rateAtEnd   (rateAtEnd),
    .ctl         (ctl)
  );

  sclkdiv_datapath #(.DIV_W(DIV_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .prescaleIn (prescaleIn),
    .rateIn     (rateIn),
    .cpol       (cpol),
    .preAtEnd   (preAtEnd),
    .rateAtEnd  (rateAtEnd),
    .sclk       (sclk),
    .riseStb    (riseStb),
    .fallStb    (fallStb)
  );

endmodule

// File: tb/sclk_divider_test.sv
module sclk_divider_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       frameActive = 1'b0;
  logic       cpol = 1'b0;
  logic [7:0] prescaleIn = 8'd0;
  logic [7:0] rateIn = 8'd0;
  logic       sclk, riseStb, fallStb;

  int    total = 0;
  int    bad = 0;
  bit    cmpOn = 1'b0;
  bit    done = 1'b0;
  string curReq = "R9";

  // behavioural reference state
  int mH = 1;
  int mCnt = 0;
  bit mSclk = 1'b0, mRise = 1'b0, mFall = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sclk_divider uut (
    .clk(clk), .rstN(rstN), .enable(enable), .frameActive(frameActive),
    .cpol(cpol), .prescaleIn(prescaleIn), .rateIn(rateIn),
    .sclk(sclk), .riseStb(riseStb), .fallStb(fallStb)
  );

  function automatic int halfOf(int p);
    return (p < 2) ? 1 : p / 2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mSclk = 1'b0; mRise = 1'b0; mFall = 1'b0; mCnt = 0; mH = 1;
    end else if (!(enable && frameActive)) begin
      mH = halfOf(int'(prescaleIn)) * (int'(rateIn) + 1);
      mCnt = 0; mSclk = cpol; mRise = 1'b0; mFall = 1'b0;
    end else begin
      mRise = 1'b0; mFall = 1'b0;
      mCnt++;
      if (mCnt == mH) begin
        mCnt = 0;
        if (mSclk) mFall = 1'b1; else mRise = 1'b1;
        mSclk = !mSclk;
      end
    end
  end

  task automatic check(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && !done) begin
      check(curReq, "sclk", int'(sclk), int'(mSclk));
      check(curReq, "riseStb", int'(riseStb), int'(mRise));
      check(curReq, "fallStb", int'(fallStb), int'(mFall));
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired in %s", curReq);
    summary();
  end

  task automatic startFrame(int p, int s, bit c);
    prescaleIn = 8'(p); rateIn = 8'(s); cpol = c;
    enable = 1'b1; frameActive = 1'b0;
    @(negedge clk);
    frameActive = 1'b1;
  endtask

  task automatic stopFrame();
    frameActive = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // counts falling edges until the wanted strobe appears
  task automatic waitStrobe(bit wantRise, int limit, output int k);
    k = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (wantRise ? riseStb : fallStb) begin
        k = i;
        break;
      end
    end
  endtask

  task automatic measure(string req, int h);
    int first, gap;
    waitStrobe(1'b1, 4 * h + 10, first);
    check("R4", "first rise delay", first, h);
    waitStrobe(1'b1, 4 * h + 10, gap);
    check(req, "rise-to-rise period", gap, 2 * h);
  endtask

  initial begin
    int k;
    repeat (2) @(negedge clk);
    cmpOn = 1'b1;
    @(negedge clk);
    check("R9", "reset sclk", int'(sclk), 0);
    check("R9", "reset riseStb", int'(riseStb), 0);
    check("R9", "reset fallStb", int'(fallStb), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: fastest setting toggles every cycle
    curReq = "R2";
    startFrame(2, 0, 1'b0);
    measure("R2", 1);
    @(negedge clk);
    check("R2", "sclk toggled", int'(sclk), 0);
    stopFrame();

    // R1: several divisor pairs
    curReq = "R1";
    startFrame(4, 0, 1'b0);  measure("R1", 2);  stopFrame();
    startFrame(6, 2, 1'b0);  measure("R1", 9);  stopFrame();
    startFrame(10, 3, 1'b0); measure("R1", 20); stopFrame();

    // R7: bit 0 ignored, low values floor to 2
    curReq = "R7";
    startFrame(0, 2, 1'b0); measure("R7", 3); stopFrame();
    startFrame(1, 2, 1'b0); measure("R7", 3); stopFrame();
    startFrame(5, 1, 1'b0); measure("R7", 4); stopFrame();

    // R5: strobe width and level
    curReq = "R5";
    startFrame(6, 0, 1'b0);
    waitStrobe(1'b1, 20, k);
    check("R5", "rise seen with sclk high", int'(sclk), 1);
    check("R5", "no fall with rise", int'(fallStb), 0);
    @(negedge clk);
    check("R5", "rise lasts one cycle", int'(riseStb), 0);
    waitStrobe(1'b0, 20, k);
    check("R5", "fall spacing", k, 2);
    check("R5", "fall seen with sclk low", int'(sclk), 0);
    stopFrame();

    // R6: mid-frame divisor change waits for the next frame
    curReq = "R6";
    startFrame(4, 1, 1'b0);
    measure("R6", 4);
    prescaleIn = 8'd20; rateIn = 8'd7;
    waitStrobe(1'b1, 100, k);
    check("R6", "period unchanged mid-frame", k, 8);
    stopFrame();
    frameActive = 1'b1;
    measure("R6", 80);
    stopFrame();

    // R3: idle level, restart from zero
    curReq = "R3";
    startFrame(4, 0, 1'b1);
    waitStrobe(1'b0, 20, k);
    check("R4", "first fall with cpol 1", k, 2);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R3", "idle sclk at cpol 1", int'(sclk), 1);
    check("R3", "no strobe when idle", int'(riseStb) + int'(fallStb), 0);
    cpol = 1'b0;
    @(negedge clk);
    check("R3", "idle follows cpol 0", int'(sclk), 0);
    cpol = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    waitStrobe(1'b0, 20, k);
    check("R3", "counters restart after idle", k, 2);
    stopFrame();
    enable = 1'b0;
    cpol = 1'b0;
    repeat (2) @(negedge clk);

    // R8: slowest setting
    curReq = "R8";
    startFrame(255, 255, 1'b0);
    measure("R8", 32512);
    stopFrame();

    summary();
  end

endmodule